// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 64-bit effective address of a memory operand from fields that a front end has already decoded. It adds an optional base register, an optional index register scaled by 1, 2, 4 or 8, and a 32-bit signed displacement. When the operand is instruction-pointer relative, the base is replaced by the address of the following instruction. The caller supplies that address as the start address of the current instruction plus its decoded length.

A 16-entry general register file sits inside the wrapper. It has one write port and two combinational read ports, one for the base and one for the index. The register number is the full 4-bit value. A request is taken on a rising edge while `req_valid` is high, and the result is presented one cycle later with `ea_valid`.

A two-state controller sequences the output:
- `ST_IDLE` means no result is being presented.
- `ST_RESULT` means `ea_out` carries the address of the request taken on the previous edge.
- The transition `take` (request high) goes from either state to `ST_RESULT`.
- The transition `drain` (request low) goes from `ST_RESULT` to `ST_IDLE`.
- The transition `wait` keeps `ST_IDLE` when no request arrives.

A narrow-address flag cuts the sum to its low 32 bits and zero-extends it. This flag does not turn off instruction-pointer-relative mode.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `ea_valid` is 0 and `ea_out` is 0. All 16 registers also reset to 0.
- R2: `ea_valid` is 1 in exactly the cycle after an edge where `req_valid` was 1, and it is 0 in every other cycle.
- R3: In normal mode the result is `base + (index << scale) + sext(disp)`, computed modulo 2^64. The base term is the register's contents, added as a number and never used as a pointer.
- R4: The `scale` code selects the index multiplier: 0 gives ×1, 1 gives ×2, 2 gives ×4 and 3 gives ×8.
- R5: A term whose valid flag is 0 contributes nothing. With neither base nor index, the result is `disp` sign-extended to 64 bits.
- R6: With `rip_rel` = 1, the result is `next_ip + sext(disp)`. Both register fields and both valid flags are ignored, including base number 13.
- R7: With `addr32` = 1, bits 63:32 of the result are 0 and bits 31:0 equal the low half of the full sum. This applies in instruction-pointer-relative mode as well.
- R8: `ea_out` keeps its last value through cycles with no request.
- R9: A write with `rf_wr_en` = 1 updates register `rf_wr_idx` at the edge. Any request taken afterwards uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_wr_en | input | 1 | Register file write enable |
| rf_wr_idx | input | 4 | Register number to write |
| rf_wr_data | input | 64 | Register write data |
| req_valid | input | 1 | Address request present this cycle |
| base_vld | input | 1 | Base register term present |
| base_idx | input | 4 | Base register number |
| index_vld | input | 1 | Index register term present |
| index_idx | input | 4 | Index register number |
| scale | input | 2 | Index scale code (×1, ×2, ×4, ×8) |
| disp | input | 32 | Signed displacement |
| rip_rel | input | 1 | Address relative to the next instruction |
| next_ip | input | 64 | Address of the following instruction |
| addr32 | input | 1 | Truncate the result to 32 bits, zero-extended |
| ea_valid | output | 1 | Result valid |
| ea_out | output | 64 | Effective address |

## Verification
The checker watches four things on every cycle:
- the one-cycle valid timing,
- the holding of the output between requests,
- a zero upper half after any narrowed request,
- the exact sums for relative requests and for displacement-only requests.

Several behaviours depend on register contents or on particular operand patterns, so only the directed scenarios can show them. These are the scale decoding, the wrap at 2^64, the ignored register 13 in relative mode, and write-then-use ordering in the register file.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    typedef enum logic [1:0] {
        SC_X1 = 2'd0,
        SC_X2 = 2'd1,
        SC_X4 = 2'd2,
        SC_X8 = 2'd3
    } scale_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ea_state_e;

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
    parameter int NREG = 16,
    parameter int AW   = 64,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [IW-1:0] rd_a_idx,
    input  logic [IW-1:0] rd_b_idx,
    output logic [AW-1:0] rd_a_data,
    output logic [AW-1:0] rd_b_data
);

    logic [AW-1:0] entry [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                entry[g] <= wr_data;
            end
        end
    end

    assign rd_a_data = entry[rd_a_idx];
    assign rd_b_data = entry[rd_b_idx];

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_gen_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 32,
    parameter int NW = 32
) (
    input  logic          base_vld,
    input  logic [AW-1:0] base_val,
    input  logic          index_vld,
    input  logic [AW-1:0] index_val,
    input  scale_e        scale,
    input  logic [DW-1:0] disp,
    input  logic          rip_rel,
    input  logic [AW-1:0] next_ip,
    input  logic          addr32,
    output logic [AW-1:0] ea
);

    logic [AW-1:0] base_term;
    logic [AW-1:0] index_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] sum;

    always_comb begin
        if (rip_rel) begin
            base_term = next_ip;
        end else if (base_vld) begin
            base_term = base_val;
        end else begin
            base_term = '0;
        end
    end

    always_comb begin
        index_term = '0;
        if (!rip_rel && index_vld) begin
            unique case (scale)
                SC_X1: index_term = index_val;
                SC_X2: index_term = index_val << 1;
                SC_X4: index_term = index_val << 2;
                SC_X8: index_term = index_val << 3;
            endcase
        end
    end

    assign disp_term = {{(AW-DW){disp[DW-1]}}, disp};
    assign sum       = base_term + index_term + disp_term;
    assign ea        = addr32 ? {{(AW-NW){1'b0}}, sum[NW-1:0]} : sum;

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_gen_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] ea_next,
    output logic          ea_valid,
    output logic [AW-1:0] ea_out
);

    ea_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_out <= '0;
        end else if (req_valid) begin
            ea_out <= ea_next;
        end
    end

    assign ea_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 64,
    parameter int DW   = 32,
    parameter int NW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rf_wr_en,
    input  logic [IW-1:0] rf_wr_idx,
    input  logic [AW-1:0] rf_wr_data,
    input  logic          req_valid,
    input  logic          base_vld,
    input  logic [IW-1:0] base_idx,
    input  logic          index_vld,
    input  logic [IW-1:0] index_idx,
    input  logic [1:0]    scale,
    input  logic [DW-1:0] disp,
    input  logic          rip_rel,
    input  logic [AW-1:0] next_ip,
    input  logic          addr32,
    output logic          ea_valid,
    output logic [AW-1:0] ea_out
);

    logic [AW-1:0] base_val;
    logic [AW-1:0] index_val;
    logic [AW-1:0] ea_next;

    ea_regfile #(.NREG(NREG), .AW(AW)) rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (rf_wr_en),
        .wr_idx    (rf_wr_idx),
        .wr_data   (rf_wr_data),
        .rd_a_idx  (base_idx),
        .rd_b_idx  (index_idx),
        .rd_a_data (base_val),
        .rd_b_data (index_val)
    );

    ea_calc #(.AW(AW), .DW(DW), .NW(NW)) calc_i (
        .base_vld  (base_vld),
        .base_val  (base_val),
        .index_vld (index_vld),
        .index_val (index_val),
        .scale     (scale_e'(scale)),
        .disp      (disp),
        .rip_rel   (rip_rel),
        .next_ip   (next_ip),
        .addr32    (addr32),
        .ea        (ea_next)
    );

    ea_ctrl #(.AW(AW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ea_next   (ea_next),
        .ea_valid  (ea_valid),
        .ea_out    (ea_out)
    );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 64,
    parameter int DW = 32,
    parameter int NW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          base_vld,
    input logic          index_vld,
    input logic [DW-1:0] disp,
    input logic          rip_rel,
    input logic [AW-1:0] next_ip,
    input logic          addr32,
    input logic          ea_valid,
    input logic [AW-1:0] ea_out
);

    function automatic logic [AW-1:0] sx(input logic [DW-1:0] d);
        return {{(AW-DW){d[DW-1]}}, d};
    endfunction

    // R2
    assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ea_valid);

    // R2
    assert_no_valid_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ea_valid);

    // R8
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(ea_out));

    // R7
    assert_narrow_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr32) |=> (ea_out[AW-1:NW] == '0));

    // R6
    assert_rip_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rip_rel && !addr32) |=>
            (ea_out == $past(next_ip) + sx($past(disp))));

    // R5
    assert_disp_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rip_rel && !base_vld && !index_vld && !addr32) |=>
            (ea_out == sx($past(disp))));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .DW(DW), .NW(NW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .base_vld  (base_vld),
    .index_vld (index_vld),
    .disp      (disp),
    .rip_rel   (rip_rel),
    .next_ip   (next_ip),
    .addr32    (addr32),
    .ea_valid  (ea_valid),
    .ea_out    (ea_out)
);

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rf_wr_en;
    logic [3:0]  rf_wr_idx;
    logic [63:0] rf_wr_data;
    logic        req_valid;
    logic        base_vld;
    logic [3:0]  base_idx;
    logic        index_vld;
    logic [3:0]  index_idx;
    logic [1:0]  scale;
    logic [31:0] disp;
    logic        rip_rel;
    logic [63:0] next_ip;
    logic        addr32;
    logic        ea_valid;
    logic [63:0] ea_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [63:0] model_rf [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .req_valid(req_valid), .base_vld(base_vld), .base_idx(base_idx),
        .index_vld(index_vld), .index_idx(index_idx), .scale(scale),
        .disp(disp), .rip_rel(rip_rel), .next_ip(next_ip), .addr32(addr32),
        .ea_valid(ea_valid), .ea_out(ea_out)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] model(input bit bv, input int bi, input bit iv, input int ii,
                                          input int sc, input logic [31:0] d, input bit rr,
                                          input logic [63:0] nip, input bit a32);
        logic [63:0] s;
        s = {{32{d[31]}}, d};
        if (rr) s = s + nip;
        else begin
            if (bv) s = s + model_rf[bi];
            if (iv) s = s + (model_rf[ii] * (64'd1 << sc));
        end
        if (a32) s = {32'h0, s[31:0]};
        return s;
    endfunction

    task automatic write_reg(input int idx, input logic [63:0] val);
        @(negedge clk);
        rf_wr_en = 1'b1; rf_wr_idx = 4'(idx); rf_wr_data = val;
        @(posedge clk);
        model_rf[idx] = val;
        @(negedge clk);
        rf_wr_en = 1'b0;
    endtask

    task automatic request(input string tag, input bit bv, input int bi, input bit iv, input int ii,
                           input int sc, input logic [31:0] d, input bit rr,
                           input logic [63:0] nip, input bit a32);
        logic [63:0] exp;
        exp = model(bv, bi, iv, ii, sc, d, rr, nip, a32);
        @(negedge clk);
        req_valid = 1'b1; base_vld = bv; base_idx = 4'(bi); index_vld = iv;
        index_idx = 4'(ii); scale = 2'(sc); disp = d; rip_rel = rr; next_ip = nip; addr32 = a32;
        @(posedge clk); #1;
        check({tag, " valid R2"}, {63'd0, ea_valid}, 64'd1);
        check(tag, ea_out, exp);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; rf_wr_en = 0; rf_wr_idx = 0; rf_wr_data = 0; req_valid = 0;
        base_vld = 0; base_idx = 0; index_vld = 0; index_idx = 0; scale = 0; disp = 0;
        rip_rel = 0; next_ip = 0; addr32 = 0;
        for (int i = 0; i < 16; i++) model_rf[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", {63'd0, ea_valid}, 64'd0);
        check("R1 out in reset", ea_out, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 valid after reset", {63'd0, ea_valid}, 64'd0);
        check("R1 out after reset", ea_out, 64'd0);
    endtask

    task automatic t_reg_reset;
        // registers still zero: base reg 7 contributes 0
        request("R1 reg reset", 1, 7, 1, 3, 0, 32'h10, 0, 0, 0);
    endtask

    task automatic t_load;
        for (int i = 0; i < 15; i++)
            write_reg(i, 64'h0000_1000_0000_0000 + 64'(i) * 64'h1111);
        write_reg(15, 64'hFFFF_FFFF_FFFF_FFF0);
    endtask

    task automatic t_general;
        request("R3 base+idx*4", 1, 1, 1, 0, 2, 32'h0, 0, 0, 0);
        request("R3 base+idx+disp", 1, 3, 1, 6, 0, 32'h40, 0, 0, 0);
        request("R3 neg disp", 1, 5, 0, 0, 0, 32'hFFFF_FFF0, 0, 0, 0);
        request("R3 wrap mod 2^64", 1, 15, 0, 0, 0, 32'h20, 0, 0, 0);
    endtask

    task automatic t_scales;
        for (int s = 0; s < 4; s++)
            request($sformatf("R4 scale code %0d", s), 0, 0, 1, 9, s, 32'h8, 0, 0, 0);
    endtask

    task automatic t_absent;
        request("R5 disp only", 0, 4, 0, 4, 3, 32'h8000_0000, 0, 0, 0);
        request("R5 index only", 0, 4, 1, 2, 1, 32'h0, 0, 0, 0);
        request("R5 base only", 1, 11, 0, 2, 3, 32'h0, 0, 0, 0);
    endtask

    task automatic t_rip;
        request("R6 rip pos", 0, 0, 0, 0, 0, 32'h7FFF_FFFF, 1, 64'h0000_7FF6_1234_5007, 0);
        request("R6 rip neg", 0, 0, 0, 0, 0, 32'hFFEA_D9ED, 1, 64'hFFFF_F800_0000_1007, 0);
        request("R6 rip ignores r13", 1, 13, 1, 2, 3, 32'h100, 1, 64'h0000_0000_0040_0007, 0);
        request("R6 r13 normal mode", 1, 13, 0, 0, 0, 32'h100, 0, 0, 0);
    endtask

    task automatic t_narrow;
        request("R7 narrow base", 1, 3, 1, 4, 3, 32'h9000_0000, 0, 0, 1);
        request("R7 narrow rip", 0, 0, 0, 0, 0, 32'hFFFF_FF00, 1, 64'h1234_5678_0000_0010, 1);
    endtask

    task automatic t_hold;
        logic [63:0] last;
        request("R8 setup", 1, 2, 0, 0, 0, 32'h55, 0, 0, 0);
        last = ea_out;
        @(negedge clk);
        base_idx = 4'd9; disp = 32'h1234;
        @(posedge clk); #1;
        check("R2 idle valid low", {63'd0, ea_valid}, 64'd0);
        check("R8 idle holds", ea_out, last);
        @(posedge clk); #1;
        check("R8 idle holds 2", ea_out, last);
    endtask

    task automatic t_write_use;
        write_reg(6, 64'h0ABC_DEF0_1357_9BDF);
        request("R9 new value used", 1, 6, 0, 0, 0, 32'h1, 0, 0, 0);
        write_reg(6, 64'h0000_0000_0000_0100);
        request("R9 rewrite used", 0, 0, 1, 6, 3, 32'h0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_reg_reset();
        t_load();
        t_general();
        t_scales();
        t_absent();
        t_rip();
        t_narrow();
        t_hold();
        t_write_use();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule